// File: doc/BRIEF.md
# Block-Mode Peripheral DMA Channel

This block is one DMA channel that copies a block of 32-bit words between system memory and one peripheral. Software programs three registers: a start address, a block word and a control word. The word count is the block count in the upper half of the block word times the block size in the lower half. Writing the control word with its busy bit set starts the channel. The direction and the start are decoded only from two exact control values.

In the memory-to-peripheral direction, the channel reads memory one word at a time and offers each word on an output stream. In the peripheral-to-memory direction, it takes words from an input stream and writes them to memory at ascending word addresses. When the block ends, the channel writes the advanced address back into the address register, clears the busy bit and pulses the interrupt for one cycle. A control value it does not recognise, or a start address outside the memory window, moves nothing. In that case it only clears busy and pulses the interrupt.

Both streams use valid/ready. A word passes on a cycle where valid and ready are both high at the clock edge. The channel holds `pout_valid` and `pout_data` steady until `pout_ready` accepts the word. It raises `pin_ready` only while it has room for one word, so a peripheral may hold back data for any number of cycles. The memory port is a request that stays up, with address and direction steady, until `mem_ready` completes it. Read data is taken in the cycle where `mem_ready` is high.

Top module: `blk_dma_chan`

## Requirements
- R1: The number of words moved equals block word bits [31:16] times bits [15:0]. Both fields are unsigned.
- R2: Control value 0x01000201 reads memory at ascending word addresses from the start address. It emits the words in that order on the output stream.
- R3: Control value 0x01000200 accepts words from the input stream in order. It writes them to ascending word addresses from the start address and writes nothing past the end of the block.
- R4: Bit 24 of the control register (index 2) reads 1 from the cycle after the start write until the transfer ends. It clears on the same edge where `irq` rises, and `irq` is high for exactly one cycle.
- R5: After a completed transfer, the address register (index 0) reads the aligned start address plus 4 times the word count.
- R6: A control write with bit 24 set and any value other than the two transfer codes moves no data. It leaves the address register unchanged. On the next edge it clears busy and pulses `irq`.
- R7: A start address with any bit above the window width (default 21 bits) set behaves as in R6.
- R8: Bits [1:0] of the address register are ignored for transfer addresses. Memory addresses are always word aligned.
- R9: While busy, writes to all three registers are ignored. The transfer in progress and the final register values are unaffected.
- R10: A word count of zero moves no data. It clears busy and pulses `irq` on the edge after the start write, and the address written back is the aligned start address.
- R11: Back-pressure rules: the output word and its valid stay stable until accepted. A memory request keeps its address and direction until `mem_ready`.
- R12: A control write with bit 24 clear is stored and readable. It starts nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 address, 1 block word, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (index 3 reads 0) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Completes the current request |
| pout_valid | output | 1 | Output stream word valid |
| pout_data | output | 32 | Output stream word |
| pout_ready | input | 1 | Peripheral accepts output word |
| pin_valid | input | 1 | Input stream word valid |
| pin_data | input | 32 | Input stream word |
| pin_ready | output | 1 | Channel can take an input word |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The handshake properties take two things for granted. The memory answers a request only while `mem_req` is high. Both stream partners follow the valid/ready rules, including a source that keeps its word until it is taken. The stimulus drives `mem_ready`, `pout_ready` and `pin_valid` from seeded random coin flips, so stalls of varying length appear on every interface. Input data comes from a counter-indexed pattern that advances only on an accepted handshake. Register writes issued while busy are made deliberately, to exercise the ignore rule rather than to violate an input assumption.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRD,
    ST_PUSH,
    ST_PULL,
    ST_MWR,
    ST_FIN
  } dma_st_t;

  localparam logic [31:0] CTL_TO_PERIPH   = 32'h0100_0201;
  localparam logic [31:0] CTL_FROM_PERIPH = 32'h0100_0200;
  localparam int          BUSY_BIT        = 24;

  localparam logic [1:0] RIDX_ADDR  = 2'd0;
  localparam logic [1:0] RIDX_BLOCK = 2'd1;
  localparam logic [1:0] RIDX_CTRL  = 2'd2;
endpackage

// File: rtl/blk_dma_decode.sv
module blk_dma_decode
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic [31:0] ctrl_word,
  input  logic [31:0] start_addr,
  input  logic [31:0] block_word,
  output logic        abort,
  output logic        to_periph,
  output logic [31:0] word_count
);
  logic addr_bad;
  logic code_ok;

  generate
    if (ADDR_W < 32) begin : g_window
      assign addr_bad = |start_addr[31:ADDR_W];
    end else begin : g_full
      assign addr_bad = 1'b0;
    end
  endgenerate

  assign code_ok    = (ctrl_word == CTL_TO_PERIPH) || (ctrl_word == CTL_FROM_PERIPH);
  assign abort      = !code_ok || addr_bad;
  assign to_periph  = ctrl_word[0];
  assign word_count = 32'(block_word[31:16]) * 32'(block_word[15:0]);
endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
  import blk_dma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              to_periph,
  input  logic [31:0]       count,
  input  logic [31:0]       base,
  output logic              done,
  output logic              wb_en,
  output logic [31:0]       end_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              pout_valid,
  output logic [DATA_W-1:0] pout_data,
  input  logic              pout_ready,
  input  logic              pin_valid,
  input  logic [DATA_W-1:0] pin_data,
  output logic              pin_ready
);
  dma_st_t           st;
  logic [31:0]       ptr;
  logic [31:0]       rem;
  logic [DATA_W-1:0] hold;
  logic              aborted;
  logic              last;

  assign last = (rem == 32'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ptr     <= '0;
      rem     <= '0;
      hold    <= '0;
      aborted <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          ptr     <= {base[31:2], 2'b00};
          rem     <= count;
          aborted <= abort;
          if (abort || count == 32'd0) st <= ST_FIN;
          else if (to_periph)          st <= ST_MRD;
          else                         st <= ST_PULL;
        end
        ST_MRD: if (mem_ready) begin
          hold <= mem_rdata;
          st   <= ST_PUSH;
        end
        ST_PUSH: if (pout_ready) begin
          ptr <= ptr + 32'd4;
          rem <= rem - 32'd1;
          st  <= last ? ST_FIN : ST_MRD;
        end
        ST_PULL: if (pin_valid) begin
          hold <= pin_data;
          st   <= ST_MWR;
        end
        ST_MWR: if (mem_ready) begin
          ptr <= ptr + 32'd4;
          rem <= rem - 32'd1;
          st  <= last ? ST_FIN : ST_PULL;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done       = (st == ST_FIN);
  assign wb_en      = !aborted;
  assign end_addr   = ptr;
  assign mem_req    = (st == ST_MRD) || (st == ST_MWR);
  assign mem_we     = (st == ST_MWR);
  assign mem_addr   = ptr;
  assign mem_wdata  = hold;
  assign pout_valid = (st == ST_PUSH);
  assign pout_data  = hold;
  assign pin_ready  = (st == ST_PULL);
endmodule

// File: rtl/blk_dma_chan.sv
module blk_dma_chan
  import blk_dma_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              pout_valid,
  output logic [DATA_W-1:0] pout_data,
  input  logic              pout_ready,
  input  logic              pin_valid,
  input  logic [DATA_W-1:0] pin_data,
  output logic              pin_ready,
  output logic              irq
);
  logic [31:0] madr_q, blk_q, ctl_q;
  logic        busy, wr_ok, start;
  logic        abort, to_periph, done, wb_en;
  logic [31:0] count, end_addr;

  assign busy  = ctl_q[BUSY_BIT];
  assign wr_ok = reg_wr_en && !busy;
  assign start = wr_ok && (reg_addr == RIDX_CTRL) && reg_wdata[BUSY_BIT];

  blk_dma_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ctrl_word  (reg_wdata),
    .start_addr (madr_q),
    .block_word (blk_q),
    .abort      (abort),
    .to_periph  (to_periph),
    .word_count (count)
  );

  blk_dma_engine #(.DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort      (abort),
    .to_periph  (to_periph),
    .count      (count),
    .base       (madr_q),
    .done       (done),
    .wb_en      (wb_en),
    .end_addr   (end_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ready  (mem_ready),
    .pout_valid (pout_valid),
    .pout_data  (pout_data),
    .pout_ready (pout_ready),
    .pin_valid  (pin_valid),
    .pin_data   (pin_data),
    .pin_ready  (pin_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      madr_q <= '0;
      blk_q  <= '0;
      ctl_q  <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (done) begin
        ctl_q[BUSY_BIT] <= 1'b0;
        irq             <= 1'b1;
        if (wb_en) madr_q <= end_addr;
      end else if (wr_ok) begin
        unique case (reg_addr)
          RIDX_ADDR:  madr_q <= reg_wdata;
          RIDX_BLOCK: blk_q  <= reg_wdata;
          RIDX_CTRL:  ctl_q  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      RIDX_ADDR:  reg_rdata = madr_q;
      RIDX_BLOCK: reg_rdata = blk_q;
      RIDX_CTRL:  reg_rdata = ctl_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [31:0]       mem_addr,
  input logic              pout_valid,
  input logic              pout_ready,
  input logic [DATA_W-1:0] pout_data,
  input logic              pin_ready
);
  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  busy_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  pout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pout_valid && !pout_ready) |=> (pout_valid && $stable(pout_data)));

  // R8
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || pout_valid || pin_ready) |-> busy);

  // R2
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_req, pout_valid, pin_ready}) <= 1);
endmodule

bind blk_dma_chan blk_dma_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (ctl_q[24]),
  .irq        (irq),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .pout_valid (pout_valid),
  .pout_ready (pout_ready),
  .pout_data  (pout_data),
  .pin_ready  (pin_ready)
);

// File: tb/tb_blk_dma_chan.sv
module tb_blk_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, pout_valid, pin_ready, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pout_data, pin_data;
  logic        mem_ready = 1'b0, pout_ready = 1'b0, pin_valid = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [256];
  logic [31:0] sink [256];
  int sink_n, src_n;
  logic clr = 1'b0;
  logic rnd_on = 1'b0;
  bit   done_flag = 0;

  always #10 clk = ~clk;

  blk_dma_chan dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .pout_valid(pout_valid),
    .pout_data(pout_data), .pout_ready(pout_ready), .pin_valid(pin_valid),
    .pin_data(pin_data), .pin_ready(pin_ready), .irq(irq)
  );

  function automatic logic [31:0] mem_pat(int i);
    return 32'hA500_0000 ^ (32'(i) * 32'h0001_0203);
  endfunction
  function automatic logic [31:0] src_pat(int k);
    return 32'h5A00_0000 + 32'(k) * 32'd7;
  endfunction

  assign mem_rdata = mem[mem_addr[9:2]];
  assign pin_data  = src_pat(src_n);

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= mem_pat(i);
      sink_n <= 0;
      src_n  <= 0;
    end else begin
      if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      if (pout_valid && pout_ready) begin
        sink[sink_n[7:0]] <= pout_data;
        sink_n <= sink_n + 1;
      end
      if (pin_valid && pin_ready) src_n <= src_n + 1;
    end
  end

  always @(negedge clk) begin
    if (rnd_on) begin
      mem_ready  <= ($urandom % 4) != 0;
      pout_ready <= ($urandom % 3) != 0;
      pin_valid  <= ($urandom % 3) != 0;
    end else begin
      mem_ready <= 1'b1; pout_ready <= 1'b1; pin_valid <= 1'b1;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic bench_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // waits at negedges for irq; returns cycles waited
  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // full transfer with checks; busy_poke adds register writes during the run
  task automatic run_xfer(bit m2p, logic [31:0] madr, logic [15:0] bc,
                          logic [15:0] bs, bit busy_poke);
    logic [31:0] d, aligned;
    int n, base, cyc;
    n = int'(bc) * int'(bs);
    aligned = {madr[31:2], 2'b00};
    base = int'(aligned[9:2]);
    bench_clear();
    wr(2'd0, madr);
    wr(2'd1, {bc, bs});
    wr(2'd2, m2p ? 32'h0100_0201 : 32'h0100_0200);
    rd(2'd2, d);
    if (n != 0 || irq == 1'b0) chk(d[24] == 1'b1, "R4 busy set", d, 32'h0100_0000);
    if (busy_poke) begin
      wr(2'd0, 32'h0000_0300);
      wr(2'd1, 32'h0001_0001);
      wr(2'd2, 32'h0100_0200);
    end
    wait_irq(cyc);
    chk(irq == 1'b1, "R4 irq seen", 32'(irq), 32'd1);
    rd(2'd2, d);
    chk(d[24] == 1'b0, "R4 busy clear with irq", d, 32'h0);
    rd(2'd0, d);
    chk(d == aligned + 32'(4 * n), "R5 end address", d, aligned + 32'(4 * n));
    if (busy_poke) begin
      rd(2'd1, d);
      chk(d == {bc, bs}, "R9 block word kept", d, {bc, bs});
    end
    @(negedge clk);
    chk(irq == 1'b0, "R4 irq one cycle", 32'(irq), 32'd0);
    if (m2p) begin
      chk(sink_n == n, "R1 word count out", 32'(sink_n), 32'(n));
      for (int k = 0; k < n; k++)
        chk(sink[k] == mem_pat(base + k), "R2 data order", sink[k], mem_pat(base + k));
    end else begin
      chk(src_n == n, "R1 word count in", 32'(src_n), 32'(n));
      for (int k = 0; k < n; k++)
        chk(mem[(base + k) % 256] == src_pat(k), "R3 memory data",
            mem[(base + k) % 256], src_pat(k));
      chk(mem[(base + n) % 256] == mem_pat((base + n) % 256), "R3 no overrun",
          mem[(base + n) % 256], mem_pat((base + n) % 256));
    end
  endtask

  // abort path: R6 / R7
  task automatic run_abort(logic [31:0] madr, logic [31:0] ctl, string req);
    logic [31:0] d;
    bench_clear();
    wr(2'd0, madr);
    wr(2'd1, 32'h0004_0004);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = ctl;
    @(negedge clk);
    reg_wr_en = 1'b0;
    rd(2'd2, d);
    chk(d[24] == 1'b1, req, d, 32'h0100_0000);
    chk(irq == 1'b0, req, 32'(irq), 32'd0);
    @(negedge clk);
    chk(irq == 1'b1, req, 32'(irq), 32'd1);
    rd(2'd2, d);
    chk(d[24] == 1'b0, req, d, 32'h0);
    rd(2'd0, d);
    chk(d == madr, req, d, madr);
    chk(sink_n == 0 && src_n == 0, req, 32'(sink_n + src_n), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, d); chk(d == 32'h0, "reset ctrl", d, 32'h0);
    rd(2'd0, d); chk(d == 32'h0, "reset addr", d, 32'h0);
    chk(irq == 1'b0 && mem_req == 1'b0 && pout_valid == 1'b0 && pin_ready == 1'b0,
        "reset outputs", {irq, mem_req, pout_valid, pin_ready}, 32'h0);

    // directed: single word each way, full ready
    run_xfer(1'b1, 32'h0000_0040, 16'd1, 16'd1, 1'b0);
    run_xfer(1'b0, 32'h0000_0080, 16'd1, 16'd1, 1'b0);
    // R8: low bits ignored
    run_xfer(1'b1, 32'h0000_0103, 16'd2, 16'd3, 1'b0);
    // R12: ctrl without start bit
    bench_clear();
    wr(2'd2, 32'h0000_0201);
    rd(2'd2, d); chk(d == 32'h0000_0201, "R12 stored", d, 32'h0000_0201);
    repeat (3) begin
      @(negedge clk);
      chk(irq == 1'b0 && mem_req == 1'b0 && pout_valid == 1'b0, "R12 no start",
          {irq, mem_req, pout_valid}, 32'h0);
    end

    rnd_on = 1'b1;
    // R10: zero count
    bench_clear();
    wr(2'd0, 32'h0000_0202);
    wr(2'd1, 32'h0000_0005);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0100_0201;
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk(irq == 1'b0, "R10 irq not yet", 32'(irq), 32'd0);
    @(negedge clk);
    chk(irq == 1'b1, "R10 irq next edge", 32'(irq), 32'd1);
    rd(2'd0, d); chk(d == 32'h0000_0200, "R10 aligned writeback", d, 32'h0000_0200);
    chk(sink_n == 0, "R10 no data", 32'(sink_n), 32'd0);

    run_abort(32'h0000_0100, 32'h0100_0401, "R6 unknown code");
    run_abort(32'h0000_0100, 32'h0100_0202, "R6 unknown code low bits");
    run_abort(32'h0020_0100, 32'h0100_0201, "R7 address outside window");

    // R9: writes during busy ignored
    run_xfer(1'b1, 32'h0000_0020, 16'd4, 16'd5, 1'b1);
    run_xfer(1'b0, 32'h0000_0024, 16'd5, 16'd4, 1'b1);

    // constrained random
    for (int t = 0; t < 10; t++) begin
      bit m2p;
      logic [31:0] a;
      m2p = 1'($urandom % 2);
      a   = 32'(($urandom % 100) * 4 + ($urandom % 4));
      run_xfer(m2p, a, 16'(1 + $urandom % 5), 16'(1 + $urandom % 6), 1'b0);
    end
    report();
  end
endmodule